// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Register Block

This block holds the software-visible control and status words of a flash memory controller: a command word, two configuration words, a controller status word carrying four error flags, and an interrupt status word carrying four completion flags plus a master pending bit. Software reaches them over a simple 16-bit register bus with a registered read port. A separate command engine reports completions and errors through single-cycle event inputs. The block drives a registered interrupt line and a ready line.

Software acknowledges interrupts by writing an AND mask into the interrupt word. Clearing the master pending bit this way also wipes the error flags. A new command is only handed to the engine while no interrupt is pending. The interrupt line polarity is chosen by a configuration bit. A cold reset and a warm reset load the same values, except in the interrupt word, where each records which reset happened.

Top module: `flashctl_irq_regs`

## Requirements
- R1: A cold reset (`rst`) gives these read values: CFG1 (address 0x1) reads 0x40C0, CFG2 (0x2) reads 0x0000, STATUS (0x3) reads 0x0000, INTSTAT (0x4) reads 0x8080 and CMD (0x0) reads 0x0000. After it `irq_o` is 1 and `rdy_o` is 1.
- R2: A warm reset (`warm_rst`) loads the same values as a cold reset, except that INTSTAT becomes 0x8010.
- R3: A done event `done_ev[i]` sets INTSTAT bit 4+i and the master bit 15. The bit order is reset, erase, program, load. An error event `err_ev[i]` sets STATUS bit 10+i, in the order command, erase, program, load. Both take effect on the next clock edge.
- R4: A write to INTSTAT replaces its contents with the old contents ANDed with the written value.
- R5: If INTSTAT bit 15 is clear after an INTSTAT write, STATUS bits 10 to 13 are cleared. If bit 15 is still set, they are kept.
- R6: `irq_o` is a register equal to INTSTAT bit 15 XOR the inverse of CFG1 bit 6. It shows an update at the same edge that updates the registers.
- R7: A write to CMD (0x0) while INTSTAT bit 15 is set is ignored: CMD keeps its value and `cmd_valid` stays low. Otherwise CMD takes the value and `cmd_valid` pulses for one cycle, with `cmd_code` holding the value.
- R8: CFG1 reads back the stored value ANDed with 0xFFE0. CFG2 reads back all 16 bits.
- R9: A CFG1 write sets `rdy_o` to bit 7 of the written value at the next edge.
- R10: If an INTSTAT write and events arrive in the same cycle, the AND mask and the error clearing are applied first, and then the events' bits are ORed in.
- R11: Reads of the ECC status address (0x5), of any unmapped address, and of ECC after a write to it all return 0. Read data appears, with `rd_valid`, one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous cold reset, active high |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| done_ev | input | 4 | Completion events: reset, erase, program, load |
| err_ev | input | 4 | Error events: command, erase, program, load |
| cmd_valid | output | 1 | One-cycle pulse when a command write is accepted |
| cmd_code | output | 16 | Current command word |
| irq_o | output | 1 | Registered interrupt line |
| rdy_o | output | 1 | Ready line, taken from CFG1 bit 7 |

## Verification
The interrupt word is driven with four kinds of stimulus, and each one separates a different fault:
- Isolated completion events show whether bits are set in the right position.
- Partial-acknowledge masks that leave the master bit set show that error flags survive an acknowledge that keeps an interrupt pending.
- Full acknowledges show that error flags are wiped.
- A write that lands in the same cycle as an event shows whether the OR is applied after the AND.

The interrupt line is checked with both polarity settings of the configuration bit. The CFG1 patterns 0x0000, 0x00FF and 0xFFBF separate the read mask from the ready and polarity bits. Command writes are attempted both while an interrupt is pending and while none is, to show the gating.

// File: rtl/fcir_pkg.sv
package fcir_pkg;
  localparam int DW        = 16;
  localparam int NEV       = 4;

  localparam int A_CMD     = 0;
  localparam int A_CFG1    = 1;
  localparam int A_CFG2    = 2;
  localparam int A_STAT    = 3;
  localparam int A_INT     = 4;
  localparam int A_ECC     = 5;

  localparam int MASTER_BIT = 15;
  localparam int DONE_LSB   = 4;
  localparam int ERR_LSB    = 10;
  localparam int POL_BIT    = 6;
  localparam int RDY_BIT    = 7;

  localparam logic [DW-1:0] CFG1_RST     = 16'h40C0;
  localparam logic [DW-1:0] CFG1_RD_MASK = 16'hFFE0;
  localparam logic [DW-1:0] INT_COLD     = 16'h8080;
  localparam logic [DW-1:0] INT_WARM     = 16'h8010;
endpackage

// File: rtl/fcir_int_ctrl.sv
module fcir_int_ctrl
  import fcir_pkg::*;
#(
  parameter int W = DW,
  parameter int N = NEV
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         warm_rst,
  input  logic         int_wr,
  input  logic [W-1:0] wdata,
  input  logic [N-1:0] done_ev,
  input  logic [N-1:0] err_ev,
  output logic [W-1:0] int_q,
  output logic [W-1:0] int_nxt,
  output logic [N-1:0] err_q
);
  logic [W-1:0] masked;
  logic [W-1:0] set_vec;
  logic [N-1:0] err_keep;
  logic [N-1:0] err_nxt;

  always_comb begin
    masked  = int_wr ? (int_q & wdata) : int_q;
    set_vec = '0;
    for (int i = 0; i < N; i++) begin
      set_vec[DONE_LSB+i] = done_ev[i];
    end
    set_vec[MASTER_BIT] = |done_ev;
    int_nxt  = masked | set_vec;
    err_keep = (int_wr && !masked[MASTER_BIT]) ? '0 : err_q;
    err_nxt  = err_keep | err_ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q <= INT_COLD;
      err_q <= '0;
    end else if (warm_rst) begin
      int_q <= INT_WARM;
      err_q <= '0;
    end else begin
      int_q <= int_nxt;
      err_q <= err_nxt;
    end
  end

  AST_AND_MASK: assert property (@(posedge clk) disable iff (rst)
    (int_wr && done_ev == '0 && !warm_rst) |=> int_q == $past(int_q & wdata)); // R4
  AST_DONE_SETS_MASTER: assert property (@(posedge clk) disable iff (rst)
    (|done_ev) |=> int_q[MASTER_BIT]); // R3
  AST_ERR_WIPE: assert property (@(posedge clk) disable iff (rst)
    (int_wr && !(int_q[MASTER_BIT] && wdata[MASTER_BIT]) && err_ev == '0) |=> err_q == '0); // R5
  AST_ERR_KEEP: assert property (@(posedge clk) disable iff (rst)
    (int_wr && int_q[MASTER_BIT] && wdata[MASTER_BIT] && !warm_rst) |=> (err_q & $past(err_q)) == $past(err_q)); // R5
endmodule

// File: rtl/fcir_cfg_regs.sv
module fcir_cfg_regs
  import fcir_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         warm_rst,
  input  logic         cfg1_wr,
  input  logic         cfg2_wr,
  input  logic         cmd_wr,
  input  logic [W-1:0] wdata,
  input  logic         int_pend,
  output logic [W-1:0] cfg1_q,
  output logic [W-1:0] cfg1_nxt,
  output logic [W-1:0] cfg2_q,
  output logic [W-1:0] cmd_q,
  output logic         cmd_valid,
  output logic         rdy_o
);
  logic cmd_take;

  always_comb begin
    cfg1_nxt = cfg1_wr ? wdata : cfg1_q;
    cmd_take = cmd_wr && !int_pend;
  end

  always_ff @(posedge clk) begin
    if (rst || warm_rst) begin
      cfg1_q    <= CFG1_RST;
      cfg2_q    <= '0;
      cmd_q     <= '0;
      cmd_valid <= 1'b0;
      rdy_o     <= CFG1_RST[RDY_BIT];
    end else begin
      cfg1_q    <= cfg1_nxt;
      cmd_valid <= cmd_take;
      if (cfg2_wr)  cfg2_q <= wdata;
      if (cmd_take) cmd_q  <= wdata;
      if (cfg1_wr)  rdy_o  <= wdata[RDY_BIT];
    end
  end

  AST_CMD_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && int_pend) |=> (!cmd_valid && $stable(cmd_q))); // R7
  AST_CMD_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !int_pend && !warm_rst) |=> (cmd_valid && cmd_q == $past(wdata))); // R7
  AST_RDY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (cfg1_wr && !warm_rst) |=> rdy_o == $past(wdata[RDY_BIT])); // R9
endmodule

// File: rtl/fcir_rd_port.sv
module fcir_rd_port
  import fcir_pkg::*;
#(
  parameter int W  = DW,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  cmd_q,
  input  logic [W-1:0]  cfg1_q,
  input  logic [W-1:0]  cfg2_q,
  input  logic [W-1:0]  stat_w,
  input  logic [W-1:0]  int_q,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    if      (addr == AW'(A_CMD))  sel = cmd_q;
    else if (addr == AW'(A_CFG1)) sel = cfg1_q & CFG1_RD_MASK;
    else if (addr == AW'(A_CFG2)) sel = cfg2_q;
    else if (addr == AW'(A_STAT)) sel = stat_w;
    else if (addr == AW'(A_INT))  sel = int_q;
    else                          sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R11
  AST_ECC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(A_ECC)) |=> rd_data == '0); // R11
endmodule

// File: rtl/flashctl_irq_regs.sv
module flashctl_irq_regs
  import fcir_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          warm_rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic [NEV-1:0] done_ev,
  input  logic [NEV-1:0] err_ev,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_code,
  output logic          irq_o,
  output logic          rdy_o
);
  localparam logic IRQ_RST = INT_COLD[MASTER_BIT] ^ ~CFG1_RST[POL_BIT];

  logic          int_wr, cfg1_wr, cfg2_wr, cmd_wr;
  logic [DW-1:0] int_q, int_nxt, cfg1_q, cfg1_nxt, cfg2_q, stat_w;
  logic [NEV-1:0] err_q;

  assign int_wr  = wr_en && addr == AW'(A_INT);
  assign cfg1_wr = wr_en && addr == AW'(A_CFG1);
  assign cfg2_wr = wr_en && addr == AW'(A_CFG2);
  assign cmd_wr  = wr_en && addr == AW'(A_CMD);

  always_comb begin
    stat_w = '0;
    stat_w[ERR_LSB +: NEV] = err_q;
  end

  fcir_int_ctrl #(.W(DW), .N(NEV)) u_int (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .int_wr(int_wr), .wdata(wdata),
    .done_ev(done_ev), .err_ev(err_ev), .int_q(int_q), .int_nxt(int_nxt),
    .err_q(err_q)
  );

  fcir_cfg_regs #(.W(DW)) u_cfg (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .cfg1_wr(cfg1_wr),
    .cfg2_wr(cfg2_wr), .cmd_wr(cmd_wr), .wdata(wdata),
    .int_pend(int_q[MASTER_BIT]), .cfg1_q(cfg1_q), .cfg1_nxt(cfg1_nxt),
    .cfg2_q(cfg2_q), .cmd_q(cmd_code), .cmd_valid(cmd_valid), .rdy_o(rdy_o)
  );

  fcir_rd_port #(.W(DW), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .cmd_q(cmd_code),
    .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .stat_w(stat_w), .int_q(int_q),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst || warm_rst) irq_o <= IRQ_RST;
    else                 irq_o <= int_nxt[MASTER_BIT] ^ ~cfg1_nxt[POL_BIT];
  end

  AST_IRQ_POLARITY: assert property (@(posedge clk) disable iff (rst)
    irq_o == (int_q[MASTER_BIT] ^ !cfg1_q[POL_BIT])); // R6
  AST_WARM_VALUE: assert property (@(posedge clk) disable iff (rst)
    warm_rst |=> (int_q == INT_WARM && err_q == '0 && cfg1_q == CFG1_RST)); // R2
endmodule

// File: tb/flashctl_irq_regs_tb.sv
module flashctl_irq_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        warm_rst = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [3:0]  done_ev = '0, err_ev = '0;
  logic        cmd_valid;
  logic [15:0] cmd_code;
  logic        irq_o, rdy_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flashctl_irq_regs u_dut (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .done_ev(done_ev), .err_ev(err_ev), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .irq_o(irq_o), .rdy_o(rdy_o)
  );

  // Monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read data got=%h", rd_data);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s got=%h exp=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string t);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", t, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ev(input logic [3:0] d, input logic [3:0] e);
    @(negedge clk);
    done_ev = d; err_ev = e;
    @(negedge clk);
    done_ev = '0; err_ev = '0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 cold reset values
    chk(16'(irq_o), 16'h1, "R1 irq after cold reset");
    chk(16'(rdy_o), 16'h1, "R1 rdy after cold reset");
    rd(4'h1, 16'h40C0, "R1 cfg1");
    rd(4'h2, 16'h0000, "R1 cfg2");
    rd(4'h3, 16'h0000, "R1 status");
    rd(4'h4, 16'h8080, "R1 intstat cold");
    rd(4'h0, 16'h0000, "R1 cmd");
    // R7 command refused while pending
    wr(4'h0, 16'h0094);
    chk(16'(cmd_valid), 16'h0, "R7 refused cmd_valid");
    rd(4'h0, 16'h0000, "R7 refused cmd");
    // R4 and-mask, R6 irq drop
    wr(4'h4, 16'h7FFF);
    chk(16'(irq_o), 16'h0, "R6 irq after ack");
    rd(4'h4, 16'h0080, "R4 and mask");
    // R7 accepted
    wr(4'h0, 16'h0094);
    chk(16'(cmd_valid), 16'h1, "R7 cmd_valid pulse");
    chk(cmd_code, 16'h0094, "R7 cmd_code");
    @(negedge clk);
    chk(16'(cmd_valid), 16'h0, "R7 pulse one cycle");
    rd(4'h0, 16'h0094, "R7 cmd readback");
    // R3 events
    ev(4'b0010, 4'b0100);
    chk(16'(irq_o), 16'h1, "R6 irq after event");
    rd(4'h4, 16'h80A0, "R3 erase done");
    rd(4'h3, 16'h1000, "R3 prog error");
    // R5 partial ack keeps errors
    wr(4'h4, 16'hFFDF);
    rd(4'h4, 16'h8080, "R4 partial ack");
    rd(4'h3, 16'h1000, "R5 errors kept");
    wr(4'h0, 16'h0080);
    rd(4'h0, 16'h0094, "R7 still refused");
    wr(4'h4, 16'h00FF);
    rd(4'h4, 16'h0080, "R4 master ack");
    rd(4'h3, 16'h0000, "R5 errors wiped");
    // R6/R8/R9 config
    wr(4'h1, 16'h0000);
    chk(16'(irq_o), 16'h1, "R6 inverted polarity idle");
    chk(16'(rdy_o), 16'h0, "R9 rdy low");
    rd(4'h1, 16'h0000, "R8 cfg1 zero");
    wr(4'h1, 16'h00FF);
    chk(16'(irq_o), 16'h0, "R6 normal polarity idle");
    chk(16'(rdy_o), 16'h1, "R9 rdy high");
    rd(4'h1, 16'h00E0, "R8 cfg1 mask");
    wr(4'h1, 16'hFFBF);
    chk(16'(irq_o), 16'h1, "R6 inverted idle again");
    rd(4'h1, 16'hFFA0, "R8 cfg1 mask high");
    ev(4'b1000, 4'b1000);
    chk(16'(irq_o), 16'h0, "R6 inverted pending");
    rd(4'h3, 16'h2000, "R3 load error");
    // R10 same-cycle write and event
    @(negedge clk);
    wr_en = 1'b1; addr = 4'h4; wdata = 16'h0000; done_ev = 4'b0001; err_ev = 4'b0001;
    @(negedge clk);
    wr_en = 1'b0; done_ev = '0; err_ev = '0;
    rd(4'h4, 16'h8010, "R10 intstat order");
    rd(4'h3, 16'h0400, "R10 status order");
    wr(4'h2, 16'hABCD);
    rd(4'h2, 16'hABCD, "R8 cfg2 full");
    // R11 ECC and unmapped
    wr(4'h5, 16'h1234);
    rd(4'h5, 16'h0000, "R11 ecc zero");
    rd(4'hF, 16'h0000, "R11 unmapped zero");
    // R2 warm reset
    @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    chk(16'(irq_o), 16'h1, "R2 irq after warm");
    chk(16'(rdy_o), 16'h1, "R2 rdy after warm");
    rd(4'h4, 16'h8010, "R2 intstat warm");
    rd(4'h1, 16'h40C0, "R2 cfg1 warm");
    rd(4'h2, 16'h0000, "R2 cfg2 warm");
    rd(4'h3, 16'h0000, "R2 status warm");
    // R1 cold reset again
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(4'h4, 16'h8080, "R1 intstat cold again");
    repeat (2) @(negedge clk);
    chk(16'(exp_q.size()), 16'h0, "R11 all reads returned");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule